// File: doc/BRIEF.md
# Dual Register-Set Task Scheduler

This controller sits in front of a video scaler. It decides which of two programmed task register sets, A or B, drives the scaler for the next piece of work. Each set carries its own enable, its own start condition, a repeat bit and a field-skip count. The scheduler arms a task and, if the task asks for it, lets a number of fields pass. It then waits until the task's trigger and the acquisition-window position are both satisfied. At that point it starts the task and holds it active until the datapath reports that the task has ended. It then picks the next task.

The scheduler counts no pixel or line positions itself. The position logic drives one level input, which is high once the acquisition window offsets have been reached in the current field. The datapath reports the end of each task with a strobe. Enable changes made while a task runs are deferred to the end of that task. A software reset returns everything to idle at once.

Top module: `dual_task_sched`

## Requirements
- R1: After hardware reset, `selB`, `taskActive`, `taskStart` and `toggleFlag` are all 0.
- R2: The start-condition encoding is 0 = immediate, 1 = next vertical sync, 2 = next field with `fid` 0, 3 = next field with `fid` 1. A task armed from idle with condition 0 starts as soon as `winReached` is high.
- R3: A task with condition 1 does not start until a `vSync` pulse has arrived after it was armed, even if `winReached` is high earlier.
- R4: A task with condition 2 or 3 starts only in a field that begins after arming, and only when `fid`, sampled while `winReached` is high, equals 0 or 1 respectively.
- R5: No task starts while `winReached` is low.
- R6: After `taskDone`, the next task cannot start before the next `vSync` pulse, even if `winReached` stays high.
- R7: When the running task's repeat bit is 1, it runs once more before handing over. After that repeated run, control passes to the other task if that task is enabled.
- R8: A skip count of N makes the task wait N extra fields. Armed from idle with condition 0, it starts in the field after the Nth `vSync`. Armed after `taskDone`, it starts in the field after the (N+1)th `vSync`.
- R9: `taskStart` is a one-cycle pulse. In the same cycle `toggleFlag` inverts and `selB` shows the started task (0 = A, 1 = B).
- R10: With both tasks enabled and neither repeating, A is armed first from idle, and the tasks then alternate A, B, A.
- R11: A change to `enA` or `enB` during a running task does not stop that task. It is applied when `taskDone` arrives.
- R12: With both tasks disabled, the scheduler stays idle with `taskActive` low. With one task enabled, that task runs field after field.
- R13: While `swRstN` is low, the scheduler is forced to idle the next cycle. `taskActive`, `toggleFlag` and `selB` are cleared and no task starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low hardware reset |
| swRstN | input | 1 | Synchronous active-low software reset |
| vSync | input | 1 | One-cycle pulse at the start of each field |
| fid | input | 1 | Field identifier |
| winReached | input | 1 | High once the window offsets are reached in the current field |
| taskDone | input | 1 | One-cycle strobe at the end of the running task |
| enA | input | 1 | Enable for task A |
| enB | input | 1 | Enable for task B |
| condA | input | 2 | Start condition of task A |
| condB | input | 2 | Start condition of task B |
| repeatA | input | 1 | Repeat bit of task A |
| repeatB | input | 1 | Repeat bit of task B |
| skipA | input | SKIP_W | Field-skip count of task A |
| skipB | input | SKIP_W | Field-skip count of task B |
| selB | output | 1 | Active task select, 0 = A, 1 = B |
| taskActive | output | 1 | High while a task runs |
| taskStart | output | 1 | One-cycle pulse at each task start |
| toggleFlag | output | 1 | Inverts at every task start |

## Verification
Several properties are checked on every cycle:
- the start pulse lasts one cycle and always coincides with an active task;
- the toggle flips exactly at a start, and the toggle and select hold between starts;
- no start happens without the window reached, or with the wrong field identifier;
- no start happens between the end of a task and the next vertical sync;
- a software reset always clears the outputs.

Some behaviours involve several fields and can only be shown by the bench's scenarios:
- the order in which tasks are chosen (alternation, the single extra run on repeat, the preference for A from idle);
- how many fields are skipped;
- the deferral of enable changes until the end of a task.

// File: rtl/dual_task_sched_pkg.sv
package dual_task_sched_pkg;

  localparam int NUM_TASKS = 2;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SKIP = 2'd1,
    ST_WAIT = 2'd2,
    ST_RUN  = 2'd3
  } schedState_t;

  typedef enum logic [1:0] {
    SC_NOW   = 2'd0,
    SC_VSYNC = 2'd1,
    SC_FID0  = 2'd2,
    SC_FID1  = 2'd3
  } startCond_t;

  // Strobes from the control FSM to the datapath registers
  typedef struct packed {
    logic arm;       // load armed task, skip counter and sync flag
    logic tgt;       // task being armed (0 = A, 1 = B)
    logic fromDone;  // arming follows the end of a task
    logic skipDec;   // one field skipped
    logic vsClear;   // vertical sync seen while waiting
    logic goStart;   // start the armed task
    logic latchEn;   // sample the enable inputs
  } schedStrobe_t;

endpackage

// File: rtl/dual_task_sched_dp.sv
module dual_task_sched_dp
  import dual_task_sched_pkg::*;
#(
  parameter int SKIP_W = 3
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  logic                               swRstN,
  input  logic                               vSync,
  input  logic                               fid,
  input  logic                               winReached,
  input  logic                               taskDone,
  input  logic                               taskActive,
  input  logic [NUM_TASKS-1:0]               enIn,
  input  logic [NUM_TASKS-1:0][1:0]          condIn,
  input  logic [NUM_TASKS-1:0]               repeatIn,
  input  logic [NUM_TASKS-1:0][SKIP_W-1:0]   skipIn,
  input  schedStrobe_t                       strobe,
  output logic [NUM_TASKS-1:0]               effEn,
  output logic [NUM_TASKS-1:0]               skipNz,
  output logic                               curSel,
  output logic                               curRepeat,
  output logic                               cntOne,
  output logic                               startOk,
  output logic                               selOut,
  output logic                               toggleOut,
  output logic                               startOut
);

  localparam logic [SKIP_W-1:0] SKIP_ONE = SKIP_W'(1);

  logic [NUM_TASKS-1:0] effEnQ;
  logic                 armSelQ;
  logic [SKIP_W-1:0]    skipCntQ;
  logic                 needVsQ;
  logic                 selQ;
  logic                 toggleQ;
  logic                 startQ;
  logic [1:0]           curCond;
  logic                 fidOk;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_TASKS; gi++) begin : g_task
      assign skipNz[gi] = |skipIn[gi];
    end
  endgenerate

  assign curCond   = condIn[armSelQ];
  assign curRepeat = repeatIn[armSelQ];
  assign fidOk     = (curCond == SC_NOW) || (curCond == SC_VSYNC) || (fid == curCond[0]);
  assign startOk   = winReached && !needVsQ && fidOk;
  assign cntOne    = (skipCntQ == SKIP_ONE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      effEnQ   <= '0;
      armSelQ  <= 1'b0;
      skipCntQ <= '0;
      needVsQ  <= 1'b0;
      selQ     <= 1'b0;
      toggleQ  <= 1'b0;
      startQ   <= 1'b0;
    end else if (!swRstN) begin
      effEnQ   <= '0;
      armSelQ  <= 1'b0;
      skipCntQ <= '0;
      needVsQ  <= 1'b0;
      selQ     <= 1'b0;
      toggleQ  <= 1'b0;
      startQ   <= 1'b0;
    end else begin
      if (strobe.latchEn) effEnQ <= enIn;
      if (strobe.arm) begin
        armSelQ  <= strobe.tgt;
        skipCntQ <= skipIn[strobe.tgt];
        needVsQ  <= strobe.fromDone || (condIn[strobe.tgt] != SC_NOW);
      end else begin
        if (strobe.skipDec) skipCntQ <= skipCntQ - SKIP_ONE;
        if (strobe.vsClear) needVsQ <= 1'b0;
      end
      startQ <= strobe.goStart;
      if (strobe.goStart) begin
        selQ    <= armSelQ;
        toggleQ <= ~toggleQ;
      end
    end
  end

  assign effEn     = effEnQ;
  assign curSel    = armSelQ;
  assign selOut    = selQ;
  assign toggleOut = toggleQ;
  assign startOut  = startQ;

  // Checker state: end of task seen since the last vertical sync
  logic doneSinceVsQ;
  logic swClrQ;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      doneSinceVsQ <= 1'b0;
      swClrQ       <= 1'b0;
    end else begin
      swClrQ <= !swRstN;
      if (!swRstN || vSync) doneSinceVsQ <= 1'b0;
      else if (taskDone && taskActive) doneSinceVsQ <= 1'b1;
    end
  end

  // R9
  start_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    startQ |=> !startQ);

  // R9
  toggle_flip_chk: assert property (@(posedge clk) disable iff (!rstN)
    startQ |-> (toggleQ != $past(toggleQ)));

  // R9
  hold_between_chk: assert property (@(posedge clk) disable iff (!rstN || !swRstN || swClrQ)
    !startQ |-> ($stable(toggleQ) && $stable(selQ)));

  // R5
  window_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    startQ |-> $past(winReached));

  // R4
  fid_match_chk: assert property (@(posedge clk) disable iff (!rstN)
    (startQ && $past(curCond[1])) |-> ($past(fid) == $past(curCond[0])));

  // R6
  no_same_field_chk: assert property (@(posedge clk) disable iff (!rstN)
    startQ |-> !doneSinceVsQ);

endmodule

// File: rtl/dual_task_sched_ctrl.sv
module dual_task_sched_ctrl
  import dual_task_sched_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 swRstN,
  input  logic                 vSync,
  input  logic                 taskDone,
  input  logic [NUM_TASKS-1:0] enIn,
  input  logic [NUM_TASKS-1:0] effEn,
  input  logic [NUM_TASKS-1:0] skipNz,
  input  logic                 curSel,
  input  logic                 curRepeat,
  input  logic                 cntOne,
  input  logic                 startOk,
  output schedStrobe_t         strobe,
  output logic                 taskActive
);

  schedState_t stateQ, stateD;
  logic        repDoneQ, repDoneD;
  logic        curEnNew, othEnNew;

  assign curEnNew = enIn[curSel];
  assign othEnNew = enIn[~curSel];

  always_comb begin
    stateD   = stateQ;
    repDoneD = repDoneQ;
    strobe   = '0;
    unique case (stateQ)
      ST_IDLE: begin
        strobe.latchEn = 1'b1;
        if (|effEn) begin
          strobe.arm = 1'b1;
          strobe.tgt = !effEn[0];
          repDoneD   = 1'b0;
          stateD     = skipNz[!effEn[0]] ? ST_SKIP : ST_WAIT;
        end
      end
      ST_SKIP: begin
        if (vSync) begin
          strobe.skipDec = 1'b1;
          if (cntOne) stateD = ST_WAIT;
        end
      end
      ST_WAIT: begin
        strobe.vsClear = vSync;
        if (startOk) begin
          strobe.goStart = 1'b1;
          stateD         = ST_RUN;
        end
      end
      ST_RUN: begin
        if (taskDone) begin
          strobe.latchEn  = 1'b1;
          strobe.fromDone = 1'b1;
          if (curRepeat && curEnNew && !repDoneQ) begin
            strobe.arm = 1'b1;
            strobe.tgt = curSel;
            repDoneD   = 1'b1;
          end else if (othEnNew) begin
            strobe.arm = 1'b1;
            strobe.tgt = ~curSel;
            repDoneD   = 1'b0;
          end else if (curEnNew) begin
            strobe.arm = 1'b1;
            strobe.tgt = curSel;
            repDoneD   = 1'b0;
          end
          if (strobe.arm) stateD = skipNz[strobe.tgt] ? ST_SKIP : ST_WAIT;
          else            stateD = ST_IDLE;
        end
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ   <= ST_IDLE;
      repDoneQ <= 1'b0;
    end else if (!swRstN) begin
      stateQ   <= ST_IDLE;
      repDoneQ <= 1'b0;
    end else begin
      stateQ   <= stateD;
      repDoneQ <= repDoneD;
    end
  end

  assign taskActive = (stateQ == ST_RUN);

  // R13
  sw_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !swRstN |=> (stateQ == ST_IDLE));

  // R11
  run_holds_chk: assert property (@(posedge clk) disable iff (!rstN || !swRstN)
    (taskActive && !taskDone) |=> taskActive);

endmodule

// File: rtl/dual_task_sched.sv
module dual_task_sched
  import dual_task_sched_pkg::*;
#(
  parameter int SKIP_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              swRstN,
  input  logic              vSync,
  input  logic              fid,
  input  logic              winReached,
  input  logic              taskDone,
  input  logic              enA,
  input  logic              enB,
  input  logic [1:0]        condA,
  input  logic [1:0]        condB,
  input  logic              repeatA,
  input  logic              repeatB,
  input  logic [SKIP_W-1:0] skipA,
  input  logic [SKIP_W-1:0] skipB,
  output logic              selB,
  output logic              taskActive,
  output logic              taskStart,
  output logic              toggleFlag
);

  logic [NUM_TASKS-1:0]             enVec;
  logic [NUM_TASKS-1:0][1:0]        condVec;
  logic [NUM_TASKS-1:0]             repVec;
  logic [NUM_TASKS-1:0][SKIP_W-1:0] skipVec;
  logic [NUM_TASKS-1:0]             effEn;
  logic [NUM_TASKS-1:0]             skipNz;
  logic                             curSel, curRepeat, cntOne, startOk;
  schedStrobe_t                     strobe;

  assign enVec   = {enB, enA};
  assign condVec = {condB, condA};
  assign repVec  = {repeatB, repeatA};
  assign skipVec = {skipB, skipA};

  dual_task_sched_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .swRstN     (swRstN),
    .vSync      (vSync),
    .taskDone   (taskDone),
    .enIn       (enVec),
    .effEn      (effEn),
    .skipNz     (skipNz),
    .curSel     (curSel),
    .curRepeat  (curRepeat),
    .cntOne     (cntOne),
    .startOk    (startOk),
    .strobe     (strobe),
    .taskActive (taskActive)
  );

  dual_task_sched_dp #(.SKIP_W(SKIP_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .swRstN     (swRstN),
    .vSync      (vSync),
    .fid        (fid),
    .winReached (winReached),
    .taskDone   (taskDone),
    .taskActive (taskActive),
    .enIn       (enVec),
    .condIn     (condVec),
    .repeatIn   (repVec),
    .skipIn     (skipVec),
    .strobe     (strobe),
    .effEn      (effEn),
    .skipNz     (skipNz),
    .curSel     (curSel),
    .curRepeat  (curRepeat),
    .cntOne     (cntOne),
    .startOk    (startOk),
    .selOut     (selB),
    .toggleOut  (toggleFlag),
    .startOut   (taskStart)
  );

  // R9
  start_active_chk: assert property (@(posedge clk) disable iff (!rstN)
    taskStart |-> taskActive);

  // R13
  sw_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    !swRstN |=> (!taskActive && !toggleFlag && !selB && !taskStart));

endmodule

// File: tb/sim_dual_task_sched.sv
`timescale 1ns/1ps
module sim_dual_task_sched;

  logic       clk = 1'b0;
  logic       rstN, swRstN, vSync, fid, winReached, taskDone;
  logic       enA, enB, repeatA, repeatB;
  logic [1:0] condA, condB;
  logic [2:0] skipA, skipB;
  logic       selB, taskActive, taskStart, toggleFlag;

  int   checks = 0;
  int   fails  = 0;
  int   startCnt;
  logic [7:0] seq;

  always #2 clk = ~clk;

  dual_task_sched #(.SKIP_W(3)) u0 (
    .clk(clk), .rstN(rstN), .swRstN(swRstN), .vSync(vSync), .fid(fid),
    .winReached(winReached), .taskDone(taskDone), .enA(enA), .enB(enB),
    .condA(condA), .condB(condB), .repeatA(repeatA), .repeatB(repeatB),
    .skipA(skipA), .skipB(skipB), .selB(selB), .taskActive(taskActive),
    .taskStart(taskStart), .toggleFlag(toggleFlag)
  );

  // start monitor, sampled 1 ns after the rising edge
  always @(posedge clk) begin
    #1;
    if (!rstN) begin
      startCnt = 0;
      seq      = '0;
    end else if (taskStart) begin
      startCnt = startCnt + 1;
      seq      = {seq[6:0], selB};
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 0; swRstN = 1; vSync = 0; fid = 0; winReached = 0; taskDone = 0;
    enA = 0; enB = 0; repeatA = 0; repeatB = 0;
    condA = 0; condB = 0; skipA = 0; skipB = 0;
    tick(3);
    rstN = 1;
    tick(2);
  endtask

  task automatic endTask();
    taskDone = 1; tick(1); taskDone = 0;
  endtask

  task automatic fieldCycle(input logic f);
    vSync = 1; fid = f; tick(1); vSync = 0;
    tick(2);
    winReached = 1;
    tick(3);
    if (taskActive) endTask();
    tick(2);
    winReached = 0;
    tick(1);
  endtask

  task automatic testReset();
    doReset();
    chk("R1 selB", selB, 0);
    chk("R1 taskActive", taskActive, 0);
    chk("R1 taskStart", taskStart, 0);
    chk("R1 toggleFlag", toggleFlag, 0);
  endtask

  task automatic testBothOff();
    doReset();
    tick(3);
    fieldCycle(0); fieldCycle(1);
    chk("R12 no start when disabled", startCnt, 0);
    chk("R12 idle taskActive", taskActive, 0);
  endtask

  task automatic testImmediate();
    doReset();
    enA = 1; condA = 0;
    tick(3);
    chk("R5 no start with window low", startCnt, 0);
    winReached = 1; tick(2);
    chk("R2 immediate start", startCnt, 1);
    chk("R2 active", taskActive, 1);
    chk("R9 toggle after first start", toggleFlag, 1);
    tick(2);
    endTask();
    tick(5);
    chk("R6 no restart in same field", startCnt, 1);
    chk("R6 inactive after done", taskActive, 0);
    winReached = 0; tick(1);
    fieldCycle(0);
    chk("R12 single task reruns", startCnt, 2);
    chk("R9 toggle after second start", toggleFlag, 0);
  endtask

  task automatic testVsyncCond();
    doReset();
    enA = 1; condA = 1;
    tick(3);
    winReached = 1; tick(4);
    chk("R3 waits for vSync", startCnt, 0);
    winReached = 0; tick(1);
    fieldCycle(0);
    chk("R3 starts after vSync", startCnt, 1);
  endtask

  task automatic testFid();
    doReset();
    enA = 1; condA = 3;
    tick(3);
    fieldCycle(0);
    chk("R4 cond3 ignores fid 0", startCnt, 0);
    fieldCycle(1);
    chk("R4 cond3 starts on fid 1", startCnt, 1);
    doReset();
    enB = 1; condB = 2;
    tick(3);
    fieldCycle(1);
    chk("R4 cond2 ignores fid 1", startCnt, 0);
    fieldCycle(0);
    chk("R4 cond2 starts on fid 0", startCnt, 1);
    chk("R4 task B selected", selB, 1);
  endtask

  task automatic testAlternate();
    doReset();
    enA = 1; enB = 1;
    tick(3);
    fieldCycle(0); fieldCycle(1); fieldCycle(0);
    chk("R10 three starts", startCnt, 3);
    chk("R10 order A,B,A", int'(seq[2:0]), 3'b010);
    chk("R9 toggle after three", toggleFlag, 1);
  endtask

  task automatic testRepeat();
    doReset();
    enA = 1; enB = 1; repeatA = 1;
    tick(3);
    for (int i = 0; i < 5; i++) fieldCycle(i[0]);
    chk("R7 five starts", startCnt, 5);
    chk("R7 order A,A,B,A,A", int'(seq[4:0]), 5'b00100);
    chk("R9 toggle after five", toggleFlag, 1);
  endtask

  task automatic testSkip();
    doReset();
    enA = 1; skipA = 3'd2;
    tick(3);
    fieldCycle(0);
    chk("R8 field 1 skipped", startCnt, 0);
    fieldCycle(1);
    chk("R8 start in field 2", startCnt, 1);
    fieldCycle(0);
    fieldCycle(1);
    chk("R8 fields 3,4 skipped", startCnt, 1);
    fieldCycle(0);
    chk("R8 start in field 5", startCnt, 2);
  endtask

  task automatic testDeferredEnable();
    doReset();
    enA = 1;
    tick(3);
    winReached = 1; tick(2);
    enA = 0; enB = 1;
    tick(3);
    chk("R11 task keeps running", taskActive, 1);
    chk("R11 no extra start", startCnt, 1);
    endTask();
    winReached = 0; tick(1);
    fieldCycle(0);
    chk("R11 B runs after done", startCnt, 2);
    chk("R11 selB shows B", selB, 1);
  endtask

  task automatic testSwReset();
    doReset();
    enA = 1;
    tick(3);
    winReached = 1; tick(2);
    chk("R13 running before reset", taskActive, 1);
    swRstN = 0; tick(1);
    chk("R13 taskActive cleared", taskActive, 0);
    chk("R13 toggle cleared", toggleFlag, 0);
    tick(3);
    chk("R13 no start while held", startCnt, 1);
    swRstN = 1; tick(4);
    chk("R13 restarts after release", startCnt, 2);
    chk("R13 toggle after restart", toggleFlag, 1);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    testReset();
    testBothOff();
    testImmediate();
    testVsyncCond();
    testFid();
    testAlternate();
    testRepeat();
    testSkip();
    testDeferredEnable();
    testSwReset();
    summary();
    $finish;
  end

endmodule